// File: doc/BRIEF.md
# NAND Access Cycle Sequencer

This block turns one host request into the pin-level timing of a single access to a NAND-style flash device. The host presents a request with a direction (read or write), a memory-space select (common or attribute), a latch kind (command, address or data), an address and write data. The block steps through a fixed sequence of phases: setup, an optional read turnaround, strobe and hold. The length of each phase comes from a programmable field counted in system clock cycles. Each field encodes its length as the field value plus one.

During the access the block holds chip select low. It drives the address and raises the command-latch or address-latch line to match the latch kind. It pulses the write or read strobe, and it opens the data-bus driver only after a programmable tristate window on writes. A low device wait input stretches the strobe. Read data is captured as the strobe ends. A one-cycle completion pulse marks the last hold cycle, and the ready output returns high on the next cycle.

Top module: `nand_seq`

## Requirements
- R1: While synchronous reset is high and on the cycle after it is applied, even mid-access, ready=1, cs_n=1, we_n=1, re_n=1, cle=0, ale=0, bus_oe=0 and done=0. After reset the last recorded latch kind is command.
- R2: A request is accepted only on a rising edge where req_valid=1 and ready=1. Once accepted, ready is 0 until the access ends, and req_valid pulses during the access are ignored.
- R3: The access starts with a setup phase of set+1 cycles. During setup cs_n=0, addr_out carries the request address and both strobes are high. The set and hold fields come from the attribute pair when req_attr=1 and from the common pair when req_attr=0.
- R4: After setup (and any turnaround), the strobe phase lasts cfg_strobe+1 cycles when wait_n stays high. we_n is low during the strobe for writes (req_write=1), and re_n is low for reads.
- R5: If wait_n is low in the last counted strobe cycle, the strobe stays asserted. It ends after the first cycle in which wait_n is sampled high.
- R6: The hold phase lasts hold+1 cycles with both strobes high, cs_n=0 and the address driven. On writes the data also stays driven. done is 1 only in the last hold cycle, and ready=1 with cs_n=1 on the next cycle.
- R7: On writes, bus_oe is 0 for the first cfg_hiz+1 cycles of the access and 1 for every later cycle of the access, with bus_out equal to the write data. On reads, bus_oe stays 0.
- R8: A read inserts a turnaround of cfg_cle_re+1 cycles between setup and strobe when the last accepted write had latch kind command (code 0). It inserts cfg_ale_re+1 cycles when that write had latch kind address (code 1). Writes with latch kind data (code 2 or 3) leave the record unchanged.
- R9: rdata takes the bus_in value of the last strobe cycle of a read. It keeps that value through later writes until the next read completes.
- R10: For the whole access, cle=1 exactly when the latch kind is 0 and ale=1 exactly when it is 1. Neither is ever high together with the other, or while idle.
- R11: All cfg_* inputs are sampled when the request is accepted. Changing them during the access does not alter any phase length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_attr | input | 1 | 1 = attribute space timing, 0 = common space |
| req_kind | input | 2 | 0 command latch, 1 address latch, 2/3 data |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| cfg_cle_re | input | 4 | Command-latch to read-strobe delay, minus one |
| cfg_ale_re | input | 4 | Address-latch to read-strobe delay, minus one |
| cfg_hiz | input | 8 | Write tristate window, minus one |
| cfg_strobe | input | 8 | Minimum strobe length, minus one |
| cfg_set_com | input | 8 | Common space setup, minus one |
| cfg_hold_com | input | 8 | Common space hold, minus one |
| cfg_set_att | input | 8 | Attribute space setup, minus one |
| cfg_hold_att | input | 8 | Attribute space hold, minus one |
| wait_n | input | 1 | Device wait, active low |
| bus_in | input | DW | Data bus from device |
| ready | output | 1 | Idle and able to accept |
| done | output | 1 | Last hold cycle of an access |
| rdata | output | DW | Captured read data |
| cs_n | output | 1 | Chip select, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| addr_out | output | AW | Address to device |
| bus_out | output | DW | Data bus to device |
| bus_oe | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with AW=10 and DW=16. The 16-bit bus lets bus_in carry a distinct value in every cycle, so the bench can tell exactly which strobe cycle the read capture used. Timing field widths stay at 8 and 4 bits, so directed accesses reach the 256-cycle and 16-cycle extremes of each field. Random accesses use small field values, which gives many short accesses that mix spaces, latch kinds, wait stretches and mid-access changes to the configuration.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int unsigned TIME_W = 8;
    localparam int unsigned DLY_W  = 4;

    typedef enum logic [1:0] {
        KIND_CMD  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_DATA = 2'd2,
        KIND_DAT2 = 2'd3
    } latch_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_TURN   = 3'd2,
        ST_STROBE = 3'd3,
        ST_HOLD   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic                  write;
        latch_kind_e           kind;
        logic                  use_turn;
        logic [TIME_W-1:0]     setup;
        logic [TIME_W-1:0]     turn;
        logic [TIME_W-1:0]     strobe;
        logic [TIME_W-1:0]     hold;
    } access_ctx_t;

    function automatic logic [TIME_W-1:0] widen_dly(input logic [DLY_W-1:0] v);
        return {{(TIME_W-DLY_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/nand_seq_ctx_sel.sv
module nand_seq_ctx_sel
    import nand_seq_pkg::*;
(
    input  logic                 req_write,
    input  logic                 req_attr,
    input  logic [1:0]           req_kind,
    input  logic [DLY_W-1:0]     cfg_cle_re,
    input  logic [DLY_W-1:0]     cfg_ale_re,
    input  logic [TIME_W-1:0]    cfg_strobe,
    input  logic [TIME_W-1:0]    cfg_set_com,
    input  logic [TIME_W-1:0]    cfg_hold_com,
    input  logic [TIME_W-1:0]    cfg_set_att,
    input  logic [TIME_W-1:0]    cfg_hold_att,
    input  logic                 last_cmd,
    output access_ctx_t          ctx_o
);
    always_comb begin
        ctx_o.write    = req_write;
        ctx_o.kind     = latch_kind_e'(req_kind);
        ctx_o.use_turn = ~req_write;
        ctx_o.setup    = req_attr ? cfg_set_att  : cfg_set_com;
        ctx_o.hold     = req_attr ? cfg_hold_att : cfg_hold_com;
        ctx_o.strobe   = cfg_strobe;
        ctx_o.turn     = last_cmd ? widen_dly(cfg_cle_re) : widen_dly(cfg_ale_re);
    end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  access_ctx_t   ctx_i,
    input  logic          wait_n,
    output seq_state_e    state_o,
    output logic          write_o,
    output latch_kind_e   kind_o,
    output logic          last_cmd_o,
    output logic          capture_o,
    output logic          done_o,
    output logic          ready_o
);
    seq_state_e          state_q;
    logic [TIME_W-1:0]   cnt_q;
    logic                write_q;
    latch_kind_e         kind_q;
    logic                use_turn_q;
    logic [TIME_W-1:0]   turn_q;
    logic [TIME_W-1:0]   strobe_q;
    logic [TIME_W-1:0]   hold_q;
    logic                last_cmd_q;
    logic                cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            write_q    <= 1'b0;
            kind_q     <= KIND_DATA;
            use_turn_q <= 1'b0;
            turn_q     <= '0;
            strobe_q   <= '0;
            hold_q     <= '0;
            last_cmd_q <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        write_q    <= ctx_i.write;
                        kind_q     <= ctx_i.kind;
                        use_turn_q <= ctx_i.use_turn;
                        turn_q     <= ctx_i.turn;
                        strobe_q   <= ctx_i.strobe;
                        hold_q     <= ctx_i.hold;
                        cnt_q      <= ctx_i.setup;
                        state_q    <= ST_SETUP;
                        if (ctx_i.write && ctx_i.kind == KIND_CMD)  last_cmd_q <= 1'b1;
                        if (ctx_i.write && ctx_i.kind == KIND_ADDR) last_cmd_q <= 1'b0;
                    end
                end
                ST_SETUP: begin
                    if (!cnt_zero) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (use_turn_q) begin
                        cnt_q   <= turn_q;
                        state_q <= ST_TURN;
                    end else begin
                        cnt_q   <= strobe_q;
                        state_q <= ST_STROBE;
                    end
                end
                ST_TURN: begin
                    if (!cnt_zero) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else begin
                        cnt_q   <= strobe_q;
                        state_q <= ST_STROBE;
                    end
                end
                ST_STROBE: begin
                    if (!cnt_zero) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (wait_n) begin
                        cnt_q   <= hold_q;
                        state_q <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
                    else           state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o    = state_q;
    assign write_o    = write_q;
    assign kind_o     = kind_q;
    assign last_cmd_o = last_cmd_q;
    assign ready_o    = (state_q == ST_IDLE);
    assign done_o     = (state_q == ST_HOLD) && cnt_zero;
    assign capture_o  = (state_q == ST_STROBE) && cnt_zero && wait_n && !write_q;

    // R6
    done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> ready_o);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (ready_o && start) |=> !ready_o);

    // R5
    strobe_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STROBE && !wait_n) |=> (state_q == ST_STROBE));
endmodule

// File: rtl/nand_seq_bus.sv
module nand_seq_bus
    import nand_seq_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               busy,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    input  logic [TIME_W-1:0]  cfg_hiz,
    input  logic               capture,
    input  logic [DW-1:0]      bus_in,
    output logic [AW-1:0]      addr_out,
    output logic [DW-1:0]      bus_out,
    output logic               bus_oe,
    output logic [DW-1:0]      rdata
);
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    logic              write_q;
    logic [TIME_W-1:0] hz_cnt_q;
    logic              hz_done_q;
    logic [DW-1:0]     rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            write_q   <= 1'b0;
            hz_cnt_q  <= '0;
            hz_done_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            if (start) begin
                addr_q    <= req_addr;
                wdata_q   <= req_wdata;
                write_q   <= req_write;
                hz_cnt_q  <= cfg_hiz;
                hz_done_q <= 1'b0;
            end else if (busy) begin
                if (hz_cnt_q != '0) hz_cnt_q  <= hz_cnt_q - 1'b1;
                else                hz_done_q <= 1'b1;
            end
            if (capture) rdata_q <= bus_in;
        end
    end

    assign bus_oe   = busy && write_q && hz_done_q;
    assign addr_out = busy ? addr_q : '0;
    assign bus_out  = bus_oe ? wdata_q : '0;
    assign rdata    = rdata_q;

    // R9
    rdata_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(rdata));

    // R7
    oe_in_access_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> busy);
endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_attr,
    input  logic [1:0]         req_kind,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    input  logic [DLY_W-1:0]   cfg_cle_re,
    input  logic [DLY_W-1:0]   cfg_ale_re,
    input  logic [TIME_W-1:0]  cfg_hiz,
    input  logic [TIME_W-1:0]  cfg_strobe,
    input  logic [TIME_W-1:0]  cfg_set_com,
    input  logic [TIME_W-1:0]  cfg_hold_com,
    input  logic [TIME_W-1:0]  cfg_set_att,
    input  logic [TIME_W-1:0]  cfg_hold_att,
    input  logic               wait_n,
    input  logic [DW-1:0]      bus_in,
    output logic               ready,
    output logic               done,
    output logic [DW-1:0]      rdata,
    output logic               cs_n,
    output logic               cle,
    output logic               ale,
    output logic               we_n,
    output logic               re_n,
    output logic [AW-1:0]      addr_out,
    output logic [DW-1:0]      bus_out,
    output logic               bus_oe
);
    access_ctx_t  ctx;
    seq_state_e   state;
    logic         write_q;
    latch_kind_e  kind_q;
    logic         last_cmd;
    logic         capture;
    logic         start;
    logic         busy;
    logic         strobe_on;

    assign start = req_valid && ready;

    nand_seq_ctx_sel u_ctx (
        .req_write    (req_write),
        .req_attr     (req_attr),
        .req_kind     (req_kind),
        .cfg_cle_re   (cfg_cle_re),
        .cfg_ale_re   (cfg_ale_re),
        .cfg_strobe   (cfg_strobe),
        .cfg_set_com  (cfg_set_com),
        .cfg_hold_com (cfg_hold_com),
        .cfg_set_att  (cfg_set_att),
        .cfg_hold_att (cfg_hold_att),
        .last_cmd     (last_cmd),
        .ctx_o        (ctx)
    );

    nand_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ctx_i      (ctx),
        .wait_n     (wait_n),
        .state_o    (state),
        .write_o    (write_q),
        .kind_o     (kind_q),
        .last_cmd_o (last_cmd),
        .capture_o  (capture),
        .done_o     (done),
        .ready_o    (ready)
    );

    assign busy = (state != ST_IDLE);

    nand_seq_bus #(.AW(AW), .DW(DW)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .busy      (busy),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cfg_hiz   (cfg_hiz),
        .capture   (capture),
        .bus_in    (bus_in),
        .addr_out  (addr_out),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .rdata     (rdata)
    );

    assign strobe_on = (state == ST_STROBE);
    assign cs_n      = ~busy;
    assign we_n      = ~(strobe_on && write_q);
    assign re_n      = ~(strobe_on && !write_q);
    assign cle       = busy && (kind_q == KIND_CMD);
    assign ale       = busy && (kind_q == KIND_ADDR);

    // R10
    latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cle, ale}));

    // R4
    strobe_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !re_n) |-> !cs_n);

    // R7
    read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> re_n);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (ready && cs_n && we_n && re_n && !bus_oe));
endmodule

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int LIMIT = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_write = 0, req_attr = 0;
    logic [1:0] req_kind = 0;
    logic [AW-1:0] req_addr = 0;
    logic [DW-1:0] req_wdata = 0;
    logic [3:0] cfg_cle_re = 0, cfg_ale_re = 0;
    logic [7:0] cfg_hiz = 0, cfg_strobe = 0, cfg_set_com = 0, cfg_hold_com = 0;
    logic [7:0] cfg_set_att = 0, cfg_hold_att = 0;
    logic wait_n = 1'b1;
    logic [DW-1:0] bus_in = 0;
    logic ready, done, cs_n, cle, ale, we_n, re_n, bus_oe;
    logic [DW-1:0] rdata, bus_out;
    logic [AW-1:0] addr_out;

    int nchk = 0, nfail = 0, cyc = 0;
    bit lastcmd = 1'b1;
    logic [DW-1:0] last_rd = '0;

    always #5 clk = ~clk;

    nand_seq #(.AW(AW), .DW(DW)) u_nand_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_attr(req_attr), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .cfg_cle_re(cfg_cle_re), .cfg_ale_re(cfg_ale_re),
        .cfg_hiz(cfg_hiz), .cfg_strobe(cfg_strobe), .cfg_set_com(cfg_set_com),
        .cfg_hold_com(cfg_hold_com), .cfg_set_att(cfg_set_att),
        .cfg_hold_att(cfg_hold_att), .wait_n(wait_n), .bus_in(bus_in),
        .ready(ready), .done(done), .rdata(rdata), .cs_n(cs_n), .cle(cle),
        .ale(ale), .we_n(we_n), .re_n(re_n), .addr_out(addr_out),
        .bus_out(bus_out), .bus_oe(bus_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({ready, cs_n, we_n, re_n, cle, ale, bus_oe, done} == 8'b1111_0000, tag,
            {ready, cs_n, we_n, re_n, cle, ale, bus_oe, done}, 8'b1111_0000);
    endtask

    task automatic randomize_cfg(input int m);
        cfg_cle_re   = 4'($urandom_range(0, (m > 15) ? 15 : m));
        cfg_ale_re   = 4'($urandom_range(0, (m > 15) ? 15 : m));
        cfg_hiz      = 8'($urandom_range(0, m));
        cfg_strobe   = 8'($urandom_range(0, m));
        cfg_set_com  = 8'($urandom_range(0, m));
        cfg_hold_com = 8'($urandom_range(0, m));
        cfg_set_att  = 8'($urandom_range(0, m));
        cfg_hold_att = 8'($urandom_range(0, m));
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic do_access(input bit wr, input bit attr, input logic [1:0] kind,
                             input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input int low, input bit scramble);
        logic [3:0] s_cle = cfg_cle_re, s_ale = cfg_ale_re;
        logic [7:0] s_hiz = cfg_hiz, s_str = cfg_strobe, s_sc = cfg_set_com;
        logic [7:0] s_hc = cfg_hold_com, s_sa = cfg_set_att, s_ha = cfg_hold_att;
        int S = (attr ? int'(s_sa) : int'(s_sc)) + 1;
        int H = (attr ? int'(s_ha) : int'(s_hc)) + 1;
        int D = wr ? 0 : (lastcmd ? int'(s_cle) + 1 : int'(s_ale) + 1);
        int W0 = int'(s_str) + 1;
        int W = imax(W0, low + 1);
        int sb = S + D + 1;
        int se = S + D + W;
        int T = se + H;
        int hzc = int'(s_hiz) + 2;
        logic [DW-1:0] base = DW'($urandom);
        string sfx = scramble ? " R11" : "";
        @(negedge clk);
        req_valid = 1; req_write = wr; req_attr = attr; req_kind = kind;
        req_addr = a; req_wdata = d;
        @(posedge clk);
        for (int c = 1; c <= T + 1; c++) begin
            string seg;
            bit ewe, ere, eoe;
            @(negedge clk);
            if (c == 1) begin
                req_valid = 0; req_addr = ~a; req_wdata = ~d;
            end
            if (c == 2 && scramble) begin
                randomize_cfg(255);
                req_valid = 1; req_write = ~wr; req_attr = ~attr;
            end
            if (c == 3) req_valid = 0;
            wait_n = !(c >= sb && c < sb + low);
            bus_in = base + DW'(c);
            #1;
            if (c <= T) begin
                if (c < S + 1)          seg = "R3";
                else if (c < sb)        seg = "R8";
                else if (c < sb + W0)   seg = "R4";
                else if (c <= se)       seg = "R5";
                else                    seg = "R6";
                seg = {seg, sfx};
                ewe = !(wr && c >= sb && c <= se);
                ere = !(!wr && c >= sb && c <= se);
                chk({ready, cs_n, we_n, re_n, done} == {1'b0, 1'b0, ewe, ere, (c == T)},
                    seg, {ready, cs_n, we_n, re_n, done},
                    {1'b0, 1'b0, ewe, ere, (c == T)});
                chk(addr_out == a, {"R3 addr", sfx}, addr_out, a);
                chk({cle, ale} == {kind == 2'd0, kind == 2'd1}, "R10", {cle, ale},
                    {kind == 2'd0, kind == 2'd1});
                eoe = wr && (c >= hzc);
                chk(bus_oe == eoe, {"R7", sfx}, bus_oe, eoe);
                if (eoe) chk(bus_out == d, "R7 R6 data", bus_out, d);
            end else begin
                chk_idle({"R6 end R2", sfx});
                if (!wr) begin
                    last_rd = base + DW'(se);
                    chk(rdata == last_rd, "R9 capture", rdata, last_rd);
                end else begin
                    chk(rdata == last_rd, "R9 keep", rdata, last_rd);
                end
            end
        end
        wait_n = 1;
        cfg_cle_re = s_cle; cfg_ale_re = s_ale; cfg_hiz = s_hiz; cfg_strobe = s_str;
        cfg_set_com = s_sc; cfg_hold_com = s_hc; cfg_set_att = s_sa; cfg_hold_att = s_ha;
        if (wr && kind == 2'd0) lastcmd = 1'b1;
        if (wr && kind == 2'd1) lastcmd = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT) begin
            nfail++;
            $display("FAIL watchdog R2 act=%0d exp=%0d", cyc, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_idle("R1 reset");
        rst = 0;
        @(negedge clk);
        chk_idle("R1 after release");

        // Directed: all fields zero, write then read
        do_access(1, 0, 2'd0, 10'h155, 16'hA5A5, 0, 0);
        do_access(0, 0, 2'd2, 10'h0AA, 16'h0, 0, 0);

        // R3: space selects distinct set/hold pairs
        cfg_set_com = 2; cfg_hold_com = 1; cfg_set_att = 9; cfg_hold_att = 6;
        do_access(1, 1, 2'd1, 10'h3FF, 16'h1234, 0, 0);
        do_access(1, 0, 2'd1, 10'h001, 16'h4321, 0, 0);

        // R8: turnaround after address latch vs command latch, max 4-bit
        cfg_ale_re = 15; cfg_cle_re = 3;
        do_access(0, 0, 2'd2, 10'h010, 16'h0, 0, 0);
        do_access(1, 0, 2'd0, 10'h020, 16'hBEEF, 0, 0);
        cfg_cle_re = 15;
        do_access(0, 1, 2'd2, 10'h030, 16'h0, 0, 0);
        do_access(1, 0, 2'd3, 10'h031, 16'hCAFE, 0, 0);
        do_access(0, 0, 2'd2, 10'h032, 16'h0, 0, 0);

        // R5: wait stretch, R4 short strobe
        cfg_strobe = 1;
        do_access(0, 0, 2'd2, 10'h040, 16'h0, 6, 0);
        do_access(1, 0, 2'd2, 10'h041, 16'h7777, 2, 0);

        // Maximum 8-bit fields: 256 cycles each
        cfg_set_att = 255; cfg_hold_att = 255; cfg_strobe = 255; cfg_hiz = 255;
        do_access(1, 1, 2'd2, 10'h2AA, 16'hF00D, 0, 0);
        cfg_hiz = 0;
        do_access(0, 1, 2'd2, 10'h2AB, 16'h0, 0, 1);

        // R1: reset mid-access
        cfg_set_com = 5; cfg_strobe = 2;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_attr = 0; req_kind = 2'd1;
        @(posedge clk);
        @(negedge clk); req_valid = 0;
        @(negedge clk); rst = 1;
        @(negedge clk);
        chk_idle("R1 mid-access reset");
        chk(rdata == '0, "R1 rdata", rdata, 0);
        rst = 0; lastcmd = 1'b1; last_rd = '0;
        @(negedge clk);
        chk_idle("R1 released");

        // Random mix
        for (int i = 0; i < 260; i++) begin
            randomize_cfg(7);
            do_access(1'($urandom), 1'($urandom), 2'($urandom),
                      AW'($urandom), DW'($urandom),
                      ($urandom_range(0, 2) == 0) ? $urandom_range(1, 6) : 0,
                      1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule